// File: doc/BRIEF.md
# Interrupt Vector Address Redirector

This block sits in the read-address path between a CPU core and its flash when the core fetches a vector. Part of the top of flash may be write-protected to hold a boot loader, and the default interrupt vectors then fall inside that protected area. When redirection is switched on and protection covers part of flash but not all of it, the block moves each interrupt-vector fetch into the matching slot at the top of the unprotected region. New handlers can then be installed without touching the protected boot area.

The translated address keeps the low nine bits of the fetch address and takes its upper seven bits from the protection boundary field. The two bytes of the reset vector are never moved. Any other address passes through unchanged. The output is registered, so the translated address appears one clock after the fetch address is presented.

Top module: `vecredir_top`

## Requirements
- R1: A synchronous, active-high `rst` clears `xlat_addr` to 0 at the next rising edge. Outside reset, `xlat_addr` shows the translation of the `fetch_addr` sampled at the previous rising edge.
- R2: A fetch address below 0xFFC0 passes through unchanged.
- R3: Fetch addresses 0xFFFE and 0xFFFF (the reset vector) pass through unchanged under every setting.
- R4: When redirection is active and the fetch address lies in 0xFFC0..0xFFFD, the output is `{prot_bound[6:0], fetch_addr[8:0]}`. The low nine bits are always kept.
- R5: When `no_redirect` is 1, every address passes through unchanged. Redirection needs this bit to be 0.
- R6: When `prot_disable` is 1 (protection off), every address passes through unchanged.
- R7: When `prot_bound` is 7'h7F, the last unprotected address is 0xFFFF and nothing is protected, so every address passes through unchanged.
- R8: The last unprotected address is `{prot_bound, 9'h1FF}`. When it lies below the flash base (default 0xC000, which means `prot_bound` < 7'h60), all of flash is protected and every address passes through unchanged. A value of 7'h60 counts as partial protection.
- R9: With 512 protected bytes (`prot_bound` = 7'h7E), 0xFFC0 maps to 0xFDC0, 0xFFE0 maps to 0xFDE0, and 0xFFFD maps to 0xFDFD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_addr | input | 16 | CPU fetch address |
| no_redirect | input | 1 | Option bit; 0 enables redirection |
| prot_disable | input | 1 | 1 turns block protection off |
| prot_bound | input | 7 | Upper bits of the last unprotected address |
| xlat_addr | output | 16 | Registered translated address |

## Verification
Directed fetches cover the window edges (0xFFBF, 0xFFC0, 0xFFFD), both reset-vector bytes and the 512-byte case. These separate an off-by-one window from a correct one and show that the reset vector is exempt. Boundary values 7'h5F, 7'h60, 7'h7E and 7'h7F separate partial protection from full protection and from none. Random traffic, biased toward the vector window, mixes all four control inputs. This checks that each enable gates the remap on its own and that the low nine bits always survive.

// File: rtl/vecredir_pkg.sv
package vecredir_pkg;
  typedef enum logic [1:0] {
    ROUTE_PASS_OUTSIDE = 2'd0,
    ROUTE_PASS_GATED   = 2'd1,
    ROUTE_REMAP        = 2'd2
  } route_e;
endpackage

// File: rtl/vecredir_prot_eval.sv
module vecredir_prot_eval #(
  parameter int ADDR_W = 16,
  parameter int KEEP_W = 9,
  parameter logic [ADDR_W-1:0] FLASH_BASE = 16'hC000,
  localparam int BND_W = ADDR_W - KEEP_W
) (
  input  logic             prot_disable,
  input  logic [BND_W-1:0] prot_bound,
  output logic             partial
);
  logic [ADDR_W-1:0] last_open;
  logic none_prot, all_prot;

  always_comb begin
    last_open = {prot_bound, {KEEP_W{1'b1}}};
    none_prot = &prot_bound;
    all_prot  = last_open < FLASH_BASE;
    partial   = !prot_disable && !none_prot && !all_prot;
  end
endmodule

// File: rtl/vecredir_window.sv
module vecredir_window #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] VEC_LO = 16'hFFC0,
  parameter logic [ADDR_W-1:0] VEC_HI = 16'hFFFD
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_window
);
  always_comb in_window = (addr >= VEC_LO) && (addr <= VEC_HI);
endmodule

// File: rtl/vecredir_top.sv
module vecredir_top
  import vecredir_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int KEEP_W = 9,
  parameter logic [ADDR_W-1:0] FLASH_BASE = 16'hC000,
  parameter logic [ADDR_W-1:0] VEC_LO = 16'hFFC0,
  parameter logic [ADDR_W-1:0] VEC_HI = 16'hFFFD,
  localparam int BND_W = ADDR_W - KEEP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              no_redirect,
  input  logic              prot_disable,
  input  logic [BND_W-1:0]  prot_bound,
  output logic [ADDR_W-1:0] xlat_addr
);
  logic partial, in_window;
  route_e route;
  logic [ADDR_W-1:0] next_addr;

  vecredir_prot_eval #(.ADDR_W(ADDR_W), .KEEP_W(KEEP_W), .FLASH_BASE(FLASH_BASE)) u_prot (
    .prot_disable(prot_disable),
    .prot_bound  (prot_bound),
    .partial     (partial)
  );

  vecredir_window #(.ADDR_W(ADDR_W), .VEC_LO(VEC_LO), .VEC_HI(VEC_HI)) u_win (
    .addr     (fetch_addr),
    .in_window(in_window)
  );

  always_comb begin
    if (!in_window)                  route = ROUTE_PASS_OUTSIDE;
    else if (no_redirect || !partial) route = ROUTE_PASS_GATED;
    else                             route = ROUTE_REMAP;
    next_addr = (route == ROUTE_REMAP) ? {prot_bound, fetch_addr[KEEP_W-1:0]} : fetch_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) xlat_addr <= '0;
    else     xlat_addr <= next_addr;
  end

  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> (xlat_addr == '0));
  assert_below_window_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(fetch_addr) < VEC_LO)) |-> (xlat_addr == $past(fetch_addr)));
  assert_reset_vector_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(fetch_addr) > VEC_HI)) |-> (xlat_addr == $past(fetch_addr)));
  assert_low_bits_kept_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (xlat_addr[KEEP_W-1:0] == $past(fetch_addr[KEEP_W-1:0])));
  assert_option_off_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(no_redirect)) |-> (xlat_addr == $past(fetch_addr)));
  assert_prot_off_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(prot_disable)) |-> (xlat_addr == $past(fetch_addr)));
  assert_none_prot_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (&$past(prot_bound))) |-> (xlat_addr == $past(fetch_addr)));
endmodule

// File: tb/tb_vecredir_top.sv
module tb_vecredir_top;
  logic clk = 1'b0;
  logic rst;
  logic [15:0] fetch_addr;
  logic no_redirect, prot_disable;
  logic [6:0] prot_bound;
  logic [15:0] xlat_addr;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vecredir_top dut (
    .clk(clk), .rst(rst), .fetch_addr(fetch_addr), .no_redirect(no_redirect),
    .prot_disable(prot_disable), .prot_bound(prot_bound), .xlat_addr(xlat_addr)
  );

  function automatic logic [15:0] model(input logic [15:0] a, input logic nr,
                                        input logic pd, input logic [6:0] b);
    logic partial;
    partial = !pd && (b != 7'h7F) && ({b, 9'h1FF} >= 16'hC000);
    if (a >= 16'hFFC0 && a <= 16'hFFFD && !nr && partial) return {b, a[8:0]};
    return a;
  endfunction

  task automatic check(input string req, input logic [15:0] exp);
    checks++;
    if (xlat_addr !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, xlat_addr, exp);
    end
  endtask

  task automatic apply(input string req, input logic [15:0] a, input logic nr,
                       input logic pd, input logic [6:0] b);
    @(negedge clk);
    fetch_addr = a; no_redirect = nr; prot_disable = pd; prot_bound = b;
    @(negedge clk);
    check(req, model(a, nr, pd, b));
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    rst = 1'b1; fetch_addr = 16'hFFE0; no_redirect = 1'b0; prot_disable = 1'b0;
    prot_bound = 7'h7E;
    @(negedge clk); @(negedge clk);
    check("R1", 16'h0000);
    rst = 1'b0;
    @(negedge clk);
    check("R1", 16'hFDE0);
    apply("R9", 16'hFFC0, 0, 0, 7'h7E);
    apply("R9", 16'hFFE0, 0, 0, 7'h7E);
    apply("R9", 16'hFFFD, 0, 0, 7'h7E);
    apply("R2", 16'hFFBF, 0, 0, 7'h7E);
    apply("R2", 16'h1234, 0, 0, 7'h70);
    apply("R3", 16'hFFFE, 0, 0, 7'h7E);
    apply("R3", 16'hFFFF, 0, 0, 7'h60);
    apply("R4", 16'hFFD3, 0, 0, 7'h6F);
    apply("R5", 16'hFFE0, 1, 0, 7'h7E);
    apply("R6", 16'hFFE0, 0, 1, 7'h7E);
    apply("R7", 16'hFFE0, 0, 0, 7'h7F);
    apply("R8", 16'hFFE0, 0, 0, 7'h5F);
    apply("R8", 16'hFFE0, 0, 0, 7'h60);
    apply("R8", 16'hFFC4, 0, 0, 7'h00);
    void'($urandom(32'd20240611));
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a;
      a = ($urandom % 2) ? (16'hFFB8 + 16'($urandom % 72)) : 16'($urandom);
      apply("R4", a, ($urandom % 4) == 0, ($urandom % 4) == 0, 7'($urandom));
    end
    rst = 1'b1;
    @(negedge clk);
    check("R1", 16'h0000);
    done = 1;
    finish_run();
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end
endmodule